// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

This block holds two independent down-counters that tick once per reference clock, plus a small interrupt cause/mask pair that records each counter's expiry. Software sets it up and reads it through a single-cycle 32-bit register port. That port has a write strobe, a read strobe and a word address. Timer 0 usually runs free as a time base. Software turns its falling value into a rising count by computing 0xFFFFFFFF minus the value. Timer 1 usually runs one-shot or periodic to raise interrupts.

The two timers share one control word, which has an enable bit and an auto-reload bit for each timer. Each timer also has its own reload register and live-value register. An expiry sets a sticky cause bit. Software clears that bit by writing a word in which the bit is 0. A separate mask bit gates each interrupt output without discarding the latched cause. The register port has no data stream, so it has no valid/ready handshake. A strobe is accepted in the cycle it is high, and read data is combinational in that same cycle.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every mapped register reads 0 and both interrupt outputs are low.
- R2: The control word is at word address 0x00. Bit 0 enables timer 0, bit 1 turns on auto-reload for timer 0, bit 2 enables timer 1, and bit 3 turns on auto-reload for timer 1. Bits 31..4 read 0.
- R3: The reload and value registers sit at these word addresses: timer 0 reload at 0x04 and value at 0x05, timer 1 reload at 0x06 and value at 0x07. A value write takes effect at the next clock edge and overrides the decrement of that edge.
- R4: An enabled timer whose value is not zero decrements by exactly 1 per clock. A disabled timer holds its value.
- R5: When an enabled timer with auto-reload has value 0, the next edge loads the reload value. With reload and value both set to N-1, expiries recur every N clocks.
- R6: When an enabled timer without auto-reload has value 0, the next edge clears that timer's enable bit in the control word. The value stays 0 and no further expiry occurs.
- R7: An enabled timer at value 0 sets its cause bit at the next edge. Timer 0 uses bit 1 and timer 1 uses bit 2 of the cause word (word address 0x44) and of the mask word (word address 0x45). All other bits of these two words read 0.
- R8: A write to the cause word clears each cause bit written as 0 and leaves each bit written as 1 unchanged. If an expiry and a clear hit the same bit at the same edge, the bit stays set.
- R9: Interrupt output i is high exactly while cause bit i and mask bit i are both set. Clearing the mask bit keeps the cause bit latched.
- R10: Reads at unmapped word addresses return 0, and writes to them change no register.
- R11: A read of a value register returns the live count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; both counters tick on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one register write per high cycle |
| bus_rd | input | 1 | Read strobe, qualifies bus_rdata |
| bus_addr | input | ADDR_W (8) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when bus_rd is low |
| irq_o | output | 2 | Per-timer interrupt, cause AND mask |

## Verification
A wrong count or a bad enable bit in a timer first shows at its value register. The error is visible on the very next read, because the value is returned live, and it shows at the cause bit and interrupt pin within one period. The bench sweeps the periodic length from 1 to 8 and the one-shot start value from 0 to 5. For each setting it counts edges until the interrupt pin rises, so an off-by-one in the reload or expiry path appears at once as a wrong edge count. A latched cause state that is wrong shows in the cycle after the cause or mask write that should have changed it.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int NTMR    = 2;
  localparam int CTL_W   = 2 * NTMR;
  localparam int EVT_LSB = 1;
  localparam int DATA_W  = 32;

  localparam logic [7:0] WA_CTRL  = 8'h00;
  localparam logic [7:0] WA_CAUSE = 8'h44;
  localparam logic [7:0] WA_MASK  = 8'h45;

  function automatic logic [7:0] rld_word(int idx);
    return 8'(8'h04 + 2 * idx);
  endfunction

  function automatic logic [7:0] val_word(int idx);
    return 8'(8'h05 + 2 * idx);
  endfunction
endpackage

// File: rtl/dtm_counter.sv
module dtm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rld_en,
  input  logic             wr_rld,
  input  logic             wr_val,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire
);
  logic at_zero;
  assign at_zero = (count == '0);
  assign expire  = en && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload <= '0;
    else if (wr_rld) reload <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_val) begin
      count <= wdata;
    end else if (en) begin
      if (!at_zero) count <= count - 1'b1;
      else if (rld_en) count <= reload;
    end
  end
endmodule

// File: rtl/dtm_irq_bank.sv
module dtm_irq_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         cause_wr,
  input  logic         mask_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] cause,
  output logic [N-1:0] mask,
  output logic [N-1:0] irq
);
  logic [N-1:0] kept;
  assign kept = cause_wr ? (cause & wbits) : cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= '0;
    else cause <= kept | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else if (mask_wr) mask <= wbits;
  end

  assign irq = cause & mask;
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import dtm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NTMR-1:0]      irq_o
);
  logic [CTL_W-1:0]            ctl_q;
  logic [NTMR-1:0][CNT_W-1:0]  cnt_q;
  logic [NTMR-1:0][CNT_W-1:0]  rld_q;
  logic [NTMR-1:0]             expire;
  logic [NTMR-1:0]             halt;
  logic [NTMR-1:0]             hit_rld;
  logic [NTMR-1:0]             hit_val;
  logic [NTMR-1:0]             cause_q;
  logic [NTMR-1:0]             mask_q;
  logic                        hit_ctrl;
  logic                        hit_cause;
  logic                        hit_mask;
  logic                        hit_any;

  assign hit_ctrl  = (bus_addr == ADDR_W'(WA_CTRL));
  assign hit_cause = (bus_addr == ADDR_W'(WA_CAUSE));
  assign hit_mask  = (bus_addr == ADDR_W'(WA_MASK));
  assign hit_any   = hit_ctrl | hit_cause | hit_mask | (|hit_rld) | (|hit_val);

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    assign hit_rld[i] = (bus_addr == ADDR_W'(rld_word(i)));
    assign hit_val[i] = (bus_addr == ADDR_W'(val_word(i)));
    assign halt[i]    = expire[i] & ~ctl_q[2*i+1];

    dtm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctl_q[2*i]),
      .rld_en (ctl_q[2*i+1]),
      .wr_rld (bus_wr && hit_rld[i]),
      .wr_val (bus_wr && hit_val[i]),
      .wdata  (bus_wdata[CNT_W-1:0]),
      .count  (cnt_q[i]),
      .reload (rld_q[i]),
      .expire (expire[i])
    );
  end

  // Software write to the control word wins over the one-shot halt.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (bus_wr && hit_ctrl) begin
      ctl_q <= bus_wdata[CTL_W-1:0];
    end else begin
      for (int i = 0; i < NTMR; i++) begin
        if (halt[i]) ctl_q[2*i] <= 1'b0;
      end
    end
  end

  dtm_irq_bank #(.N(NTMR)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (expire),
    .cause_wr (bus_wr && hit_cause),
    .mask_wr  (bus_wr && hit_mask),
    .wbits    (bus_wdata[EVT_LSB +: NTMR]),
    .cause    (cause_q),
    .mask     (mask_q),
    .irq      (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_ctrl)  bus_rdata[CTL_W-1:0]       = ctl_q;
      if (hit_cause) bus_rdata[EVT_LSB +: NTMR] = cause_q;
      if (hit_mask)  bus_rdata[EVT_LSB +: NTMR] = mask_q;
      for (int i = 0; i < NTMR; i++) begin
        if (hit_rld[i]) bus_rdata[CNT_W-1:0] = rld_q[i];
        if (hit_val[i]) bus_rdata[CNT_W-1:0] = cnt_q[i];
      end
    end
  end
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker
  import dtm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NTMR-1:0]            irq_o,
  input logic [CTL_W-1:0]           ctl,
  input logic [NTMR-1:0][CNT_W-1:0] cnt,
  input logic [NTMR-1:0]            cause,
  input logic [NTMR-1:0]            mask,
  input logic [NTMR-1:0]            hit_val,
  input logic                       hit_ctrl,
  input logic                       hit_cause,
  input logic                       hit_any
);
  for (genvar i = 0; i < NTMR; i++) begin : g_chk
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[2*i] && !(bus_wr && hit_val[i])) |=> $stable(cnt[i])); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[2*i] && cnt[i] != '0 && !(bus_wr && hit_val[i])) |=> cnt[i] == $past(cnt[i]) - 1'b1); // R4
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[2*i] && !ctl[2*i+1] && cnt[i] == '0 && !(bus_wr && hit_ctrl)) |=> !ctl[2*i]); // R6
    AST_CAUSE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[2*i] && cnt[i] == '0) |=> cause[i]); // R7
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cause[i] && !(bus_wr && hit_cause)) |=> cause[i]); // R8
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !mask[i] |-> !irq_o[i]); // R9
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit_any) |-> bus_rdata == '0); // R10
endmodule

bind dual_down_timer dtm_checker #(.CNT_W(CNT_W)) u_dtm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .ctl       (ctl_q),
  .cnt       (cnt_q),
  .cause     (cause_q),
  .mask      (mask_q),
  .hit_val   (hit_val),
  .hit_ctrl  (hit_ctrl),
  .hit_cause (hit_cause),
  .hit_any   (hit_any)
);

// File: tb/test_dual_down_timer.sv
`timescale 1ns/1ps
module test_dual_down_timer;
  localparam logic [7:0] A_CTRL = 8'h00, A_R0 = 8'h04, A_V0 = 8'h05,
                         A_R1 = 8'h06, A_V1 = 8'h07, A_CAUSE = 8'h44, A_MASK = 8'h45;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_down_timer i_dual_down_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic br(logic [7:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1;
    d = rdata;
    rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit mapped(int a);
    return a == 0 || (a >= 4 && a <= 7) || a == 'h44 || a == 'h45;
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int j;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    br(A_CTRL, v);  chk("R1 ctrl", v, 0);
    br(A_R0, v);    chk("R1 rld0", v, 0);
    br(A_V0, v);    chk("R1 val0", v, 0);
    br(A_R1, v);    chk("R1 rld1", v, 0);
    br(A_V1, v);    chk("R1 val1", v, 0);
    br(A_CAUSE, v); chk("R1 cause", v, 0);
    br(A_MASK, v);  chk("R1 mask", v, 0);
    chk("R1 irq", {30'd0, irq}, 0);

    // R2 upper control bits read zero
    bw(A_CTRL, 32'hFFFF_FFF0); br(A_CTRL, v); chk("R2 upper bits", v, 0);

    // R3 reload and value registers; R4 disabled hold
    bw(A_R0, 32'h1234_5678); br(A_R0, v); chk("R3 rld0", v, 32'h1234_5678);
    bw(A_R1, 32'hCAFE_0001); br(A_R1, v); chk("R3 rld1", v, 32'hCAFE_0001);
    bw(A_V1, 32'h0000_0400); idle(7); br(A_V1, v); chk("R4 hold when disabled", v, 32'h400);

    // R10 unmapped sweep
    for (int a = 0; a < 256; a++) begin
      if (!mapped(a)) begin
        bw(8'(a), 32'hFFFF_FFFF);
        br(8'(a), v); chk("R10 unmapped read", v, 0);
      end
    end
    br(A_R0, v);    chk("R10 rld0 untouched", v, 32'h1234_5678);
    br(A_R1, v);    chk("R10 rld1 untouched", v, 32'hCAFE_0001);
    br(A_V1, v);    chk("R10 val1 untouched", v, 32'h400);
    br(A_CTRL, v);  chk("R10 ctrl untouched", v, 0);
    br(A_MASK, v);  chk("R10 mask untouched", v, 0);
    br(A_CAUSE, v); chk("R10 cause untouched", v, 0);

    // R11 / R4 free-running timer 0
    bw(A_V0, 32'hFFFF_FFFF); bw(A_R0, 32'hFFFF_FFFF); bw(A_CTRL, 32'h3);
    br(A_V0, v); chk("R11 start value", v, 32'hFFFF_FFFF);
    for (int k = 1; k <= 12; k++) begin
      br(A_V0, v); idle(k); br(A_V0, v2);
      chk("R4 decrement per clock", v - v2, 32'(k));
    end

    // R3 value write overrides decrement
    bw(A_V0, 32'd1000); br(A_V0, v); chk("R3 write overrides", v, 32'd1000);
    idle(3); br(A_V0, v); chk("R3 counts after write", v, 32'd997);
    bw(A_V0, 32'hFFFF_FFFF);

    // R5 periodic timer 1, with R8 same-edge set wins at N=1
    bw(A_MASK, 32'h4); br(A_MASK, v); chk("R7 mask readback", v, 32'h4);
    for (int n = 1; n <= 8; n++) begin
      bw(A_CTRL, 32'h3); bw(A_CAUSE, ~32'h4);
      bw(A_R1, 32'(n - 1)); bw(A_V1, 32'(n - 1)); bw(A_CTRL, 32'hF);
      j = 0;
      do begin idle(1); j++; end while (!irq[1] && j < 50);
      chk("R5 first period", 32'(j), 32'(n));
      bw(A_CAUSE, ~32'h4); br(A_CAUSE, v);
      if (n == 1) begin
        chk("R8 set wins over clear", v, 32'h4);
      end else begin
        chk("R8 cleared", v, 0);
        j = 0;
        do begin idle(1); j++; end while (!irq[1] && j < 50);
        chk("R5 next period", 32'(j), 32'(n - 1));
      end
    end

    // R9 mask gating keeps cause
    bw(A_CTRL, 32'h3);
    bw(A_MASK, 32'h0); chk("R9 masked irq low", {31'd0, irq[1]}, 0);
    br(A_CAUSE, v); chk("R9 cause retained", v, 32'h4);
    bw(A_MASK, 32'h4); chk("R9 unmasked irq high", {31'd0, irq[1]}, 1);
    bw(A_CAUSE, ~32'h4); chk("R9 irq after ack", {31'd0, irq[1]}, 0);
    bw(A_MASK, 32'hFFFF_FFFF); br(A_MASK, v); chk("R7 mask only bits 2:1", v, 32'h6);
    bw(A_MASK, 32'h4);

    // R6 one-shot timer 1
    for (int s = 0; s <= 5; s++) begin
      bw(A_CTRL, 32'h3); bw(A_CAUSE, ~32'h4);
      bw(A_V1, 32'(s)); bw(A_CTRL, 32'h7);
      j = 0;
      do begin idle(1); j++; end while (!irq[1] && j < 50);
      chk("R6 one-shot latency", 32'(j), 32'(s + 1));
      br(A_CTRL, v); chk("R6 enable cleared", v, 32'h3);
      br(A_V1, v);   chk("R6 stays at zero", v, 0);
      bw(A_CAUSE, ~32'h4); idle(6);
      br(A_CAUSE, v); chk("R6 no refire", v, 0);
    end

    // R7 timer 0 event on bit 1
    bw(A_CTRL, 32'h0); bw(A_V0, 32'd2); bw(A_MASK, 32'h6); bw(A_CTRL, 32'h1);
    j = 0;
    do begin idle(1); j++; end while (!irq[0] && j < 50);
    chk("R7 timer0 expiry latency", 32'(j), 32'd3);
    br(A_CAUSE, v); chk("R7 timer0 cause bit1", v, 32'h2);
    chk("R9 timer1 irq low", {31'd0, irq[1]}, 0);

    // R8 selective clear
    bw(A_V1, 32'd0); bw(A_CTRL, 32'h4); idle(2);
    br(A_CAUSE, v); chk("R8 both causes", v, 32'h6);
    bw(A_CAUSE, 32'hFFFF_FFFD); br(A_CAUSE, v); chk("R8 clear bit1 only", v, 32'h4);
    bw(A_CAUSE, 32'hFFFF_FFFF); br(A_CAUSE, v); chk("R8 ones leave set", v, 32'h4);
    bw(A_CAUSE, 32'h0); br(A_CAUSE, v); chk("R8 all cleared", v, 0);
    chk("R9 irq both low", {30'd0, irq}, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule